// File: doc/BRIEF.md
# Cache-Block Operation Guard and Zeroing Sequencer

This block sits between instruction decode and the memory subsystem of a processor core. It takes cache-block requests of four kinds (zero, clean, flush, invalidate) and decides whether each one may proceed. The decision uses the requester's privilege level, a virtualization flag, one enable field from each of three environment-configuration registers (machine, hypervisor, supervisor) and two permission-probe answers (load allowed, store allowed). The probe answers are computed elsewhere and arrive with the request. A refused request produces a one-cycle exception pulse with a cause code. An accepted clean, flush or invalidate produces a one-cycle completion pulse. The caches themselves are not modelled.

An accepted zero request is turned into a burst of full-strobe, all-zero writes that cover the whole aligned block, one beat per handshake on a valid/ready write port. The burst is issued whether or not the target region is cacheable. The completion pulse follows the final beat. On the cycle the final beat is taken, the block can already accept the next request, so blocks can be zeroed back to back.

Top module: `cbo_guard`

## Requirements
- R1: With privilege below machine (machine=3, supervisor=1, user=0), a clear machine enable bit for the operation raises exception code 2 (illegal instruction).
- R2: When virtualized, a virtual-instruction fault (code 22) is raised if the privilege is at or below supervisor and the hypervisor enable bit is clear, or if the privilege is user and the supervisor enable bit is clear.
- R3: When not virtualized, a user-level request with a clear supervisor enable bit raises code 2.
- R4: Each enable field is 3 bits. Bit 0 gates zero (op code 0), bit 1 gates clean (op 1) and flush (op 2), and bit 2 gates invalidate (op 3).
- R5: The checks are applied in the order machine, virtual, supervisor, access, and the first one that fails sets the code.
- R6: `blk_addr` is the request address with its low log2(BLK_BYTES) bits cleared, and every write falls inside that block.
- R7: A zero request without store permission raises code 7 (store fault).
- R8: Clean, flush and invalidate succeed when load or store permission is granted, and raise code 7 only when both are denied.
- R9: A permitted zero request issues BLK_BYTES/BEAT_BYTES writes at `blk_addr + i*BEAT_BYTES` in ascending order. Each write has zero data and all strobes set, and its address and valid are held while `wr_ready` is low.
- R10: No write is issued for a request that raises an exception.
- R11: `exc_valid`, `exc_code`, `blk_addr` and `done` (for clean, flush or invalidate) appear in the cycle after acceptance. For a zero request, `done` pulses in the cycle after the last beat is taken.
- R12: `req_ready` is high when idle and also in the cycle where the last zero beat is taken. It is low during the rest of a burst.
- R13: After reset, `req_ready` is 1 and `exc_valid`, `done` and `wr_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_op | input | 2 | 0 zero, 1 clean, 2 flush, 3 invalidate |
| req_priv | input | 2 | Privilege: 0 user, 1 supervisor, 3 machine |
| req_virt | input | 1 | Requester runs virtualized |
| req_addr | input | AW | Operand address |
| cfg_menv | input | 3 | Machine enable field |
| cfg_henv | input | 3 | Hypervisor enable field |
| cfg_senv | input | 3 | Supervisor enable field |
| probe_ld_ok | input | 1 | Load access to the block permitted |
| probe_st_ok | input | 1 | Store access to the block permitted |
| exc_valid | output | 1 | One-cycle exception pulse |
| exc_code | output | 5 | Cause: 2 illegal, 7 store fault, 22 virtual |
| blk_addr | output | AW | Aligned block address of last accepted request |
| done | output | 1 | One-cycle completion pulse |
| wr_valid | output | 1 | Zero write beat valid |
| wr_ready | input | 1 | Write beat taken |
| wr_addr | output | AW | Beat address |
| wr_data | output | 8*BEAT_BYTES | Beat data (zero) |
| wr_strb | output | BEAT_BYTES | Byte strobes (all set) |

## Verification
Two events can share a single cycle: the handshake that takes the final zero beat and the acceptance of the next request. In that case the `done` pulse of the finishing burst lands in the same cycle as the `exc_valid` pulse or the first write beat of the new request. The bench provokes this directly. It holds `wr_ready` high through a burst, presents a new refused request exactly on the last beat, and requires `req_ready` high there. In the following cycle it requires `done` and `exc_valid` together, with the right cause code and no write in flight. A second case repeats this with a permitted zero request and requires its burst to restart from beat 0 at the new block.

// File: rtl/cbo_guard_pkg.sv
package cbo_guard_pkg;

  typedef enum logic [1:0] {
    CBO_ZERO  = 2'd0,
    CBO_CLEAN = 2'd1,
    CBO_FLUSH = 2'd2,
    CBO_INVAL = 2'd3
  } cbo_op_e;

  localparam logic [1:0] PL_USER    = 2'd0;
  localparam logic [1:0] PL_SUPER   = 2'd1;
  localparam logic [1:0] PL_MACHINE = 2'd3;

  localparam logic [4:0] XC_NONE    = 5'd0;
  localparam logic [4:0] XC_ILLEGAL = 5'd2;
  localparam logic [4:0] XC_STORE   = 5'd7;
  localparam logic [4:0] XC_VIRTUAL = 5'd22;

  // which bit of a 3-bit enable field gates this operation
  function automatic logic [1:0] enable_index(cbo_op_e op);
    case (op)
      CBO_ZERO:  return 2'd0;
      CBO_INVAL: return 2'd2;
      default:   return 2'd1;
    endcase
  endfunction

  // access rule: zero needs store; others need load, falling back to store
  function automatic logic access_denied(cbo_op_e op, logic ld_ok, logic st_ok);
    if (op == CBO_ZERO) return !st_ok;
    return !(ld_ok || st_ok);
  endfunction

endpackage

// File: rtl/cbo_perm_check.sv
module cbo_perm_check
  import cbo_guard_pkg::*;
(
  input  logic [1:0] op,
  input  logic [1:0] priv,
  input  logic       virt,
  input  logic [2:0] cfg_m,
  input  logic [2:0] cfg_h,
  input  logic [2:0] cfg_s,
  input  logic       ld_ok,
  input  logic       st_ok,
  output logic       m_block,
  output logic       v_block,
  output logic       s_block,
  output logic       acc_block,
  output logic       fault,
  output logic [4:0] code
);
  cbo_op_e    op_e;
  logic [1:0] idx;
  logic       en_m, en_h, en_s;

  always_comb begin
    op_e = cbo_op_e'(op);
    idx  = enable_index(op_e);
    en_m = cfg_m[idx];
    en_h = cfg_h[idx];
    en_s = cfg_s[idx];
  end

  assign m_block   = (priv != PL_MACHINE) && !en_m;
  assign v_block   = virt && (((priv <= PL_SUPER) && !en_h) ||
                              ((priv < PL_SUPER) && !en_s));
  assign s_block   = !virt && (priv < PL_SUPER) && !en_s;
  assign acc_block = access_denied(op_e, ld_ok, st_ok);

  always_comb begin
    fault = 1'b1;
    if (m_block)        code = XC_ILLEGAL;
    else if (v_block)   code = XC_VIRTUAL;
    else if (s_block)   code = XC_ILLEGAL;
    else if (acc_block) code = XC_STORE;
    else begin
      fault = 1'b0;
      code  = XC_NONE;
    end
  end
endmodule

// File: rtl/cbo_zero_seq.sv
module cbo_zero_seq #(
  parameter int AW         = 32,
  parameter int BLK_BYTES  = 64,
  parameter int BEAT_BYTES = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base,
  input  logic          wr_ready,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic          wr_last,
  output logic          finish
);
  localparam int BEATS = BLK_BYTES / BEAT_BYTES;
  localparam int CW    = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [CW-1:0] LAST = CW'(BEATS - 1);

  logic          busy;
  logic [CW-1:0] beat;
  logic [AW-1:0] base_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      beat   <= '0;
      base_q <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      beat   <= '0;
      base_q <= base;
    end else if (busy && wr_ready) begin
      if (beat == LAST) busy <= 1'b0;
      else              beat <= beat + 1'b1;
    end
  end

  assign wr_valid = busy;
  assign wr_last  = (beat == LAST);
  assign wr_addr  = base_q + AW'(beat) * AW'(BEAT_BYTES);
  assign finish   = busy && wr_ready && wr_last;
endmodule

// File: rtl/cbo_guard.sv
module cbo_guard
  import cbo_guard_pkg::*;
#(
  parameter int AW         = 32,
  parameter int BLK_BYTES  = 64,
  parameter int BEAT_BYTES = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [1:0]              req_op,
  input  logic [1:0]              req_priv,
  input  logic                    req_virt,
  input  logic [AW-1:0]           req_addr,
  input  logic [2:0]              cfg_menv,
  input  logic [2:0]              cfg_henv,
  input  logic [2:0]              cfg_senv,
  input  logic                    probe_ld_ok,
  input  logic                    probe_st_ok,
  output logic                    exc_valid,
  output logic [4:0]              exc_code,
  output logic [AW-1:0]           blk_addr,
  output logic                    done,
  output logic                    wr_valid,
  input  logic                    wr_ready,
  output logic [AW-1:0]           wr_addr,
  output logic [8*BEAT_BYTES-1:0] wr_data,
  output logic [BEAT_BYTES-1:0]   wr_strb
);
  localparam logic [AW-1:0] ALIGN_MASK = ~AW'(BLK_BYTES - 1);

  logic          accept, chk_fault, start_zero, seq_finish, wr_last;
  logic          m_block, v_block, s_block, acc_block;
  logic [4:0]    chk_code;
  logic [AW-1:0] aligned;

  cbo_perm_check u_perm (
    .op(req_op), .priv(req_priv), .virt(req_virt),
    .cfg_m(cfg_menv), .cfg_h(cfg_henv), .cfg_s(cfg_senv),
    .ld_ok(probe_ld_ok), .st_ok(probe_st_ok),
    .m_block(m_block), .v_block(v_block), .s_block(s_block),
    .acc_block(acc_block), .fault(chk_fault), .code(chk_code)
  );

  cbo_zero_seq #(.AW(AW), .BLK_BYTES(BLK_BYTES), .BEAT_BYTES(BEAT_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start_zero), .base(aligned),
    .wr_ready(wr_ready), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_last(wr_last), .finish(seq_finish)
  );

  assign aligned    = req_addr & ALIGN_MASK;
  assign req_ready  = !wr_valid || seq_finish;
  assign accept     = req_valid && req_ready;
  assign start_zero = accept && !chk_fault && (cbo_op_e'(req_op) == CBO_ZERO);
  assign wr_data    = '0;
  assign wr_strb    = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exc_valid <= 1'b0;
      exc_code  <= XC_NONE;
      blk_addr  <= '0;
      done      <= 1'b0;
    end else begin
      exc_valid <= accept && chk_fault;
      if (accept && chk_fault) exc_code <= chk_code;
      if (accept) blk_addr <= aligned;
      done <= (accept && !chk_fault && (cbo_op_e'(req_op) != CBO_ZERO)) || seq_finish;
    end
  end
endmodule

// File: rtl/cbo_guard_chk.sv
module cbo_guard_chk #(
  parameter int AW         = 32,
  parameter int BLK_BYTES  = 64,
  parameter int BEAT_BYTES = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    accept,
  input logic [1:0]              req_op,
  input logic [1:0]              req_priv,
  input logic [AW-1:0]           req_addr,
  input logic [2:0]              cfg_menv,
  input logic                    probe_ld_ok,
  input logic                    probe_st_ok,
  input logic                    exc_valid,
  input logic [4:0]              exc_code,
  input logic [AW-1:0]           blk_addr,
  input logic                    done,
  input logic                    wr_valid,
  input logic                    wr_ready,
  input logic [AW-1:0]           wr_addr,
  input logic [8*BEAT_BYTES-1:0] wr_data,
  input logic [BEAT_BYTES-1:0]   wr_strb
);
  localparam logic [AW-1:0] LOW = AW'(BLK_BYTES - 1);

  assert_machine_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_priv != 2'd3 && cfg_menv == 3'b000 |=> exc_valid && exc_code == 5'd2);

  assert_code_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (exc_code == 5'd2 || exc_code == 5'd7 || exc_code == 5'd22));

  assert_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (blk_addr & LOW) == '0 && (blk_addr & ~LOW) == ($past(req_addr) & ~LOW));

  assert_in_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_addr & ~LOW) == blk_addr && (wr_addr % BEAT_BYTES) == 0);

  assert_load_path_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_priv == 2'd3 && req_op != 2'd0 && probe_ld_ok |=> !exc_valid && done);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr));

  assert_zero_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_data == '0 && (&wr_strb));

  assert_no_write_on_exc_R10: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> !wr_valid);

  assert_zero_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_priv == 2'd3 && req_op == 2'd0 && !probe_st_ok |=> exc_valid && exc_code == 5'd7);
endmodule

bind cbo_guard cbo_guard_chk #(.AW(AW), .BLK_BYTES(BLK_BYTES), .BEAT_BYTES(BEAT_BYTES)) u_chk (.*);

// File: tb/tb_cbo_guard.sv
module tb_cbo_guard;
  localparam int AW = 32, BLK = 64, BB = 8, BEATS = BLK / BB;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_virt = 0, probe_ld_ok = 0, probe_st_ok = 0, wr_ready = 0;
  logic [1:0] req_op = 0, req_priv = 0;
  logic [AW-1:0] req_addr = 0;
  logic [2:0] cfg_menv = 0, cfg_henv = 0, cfg_senv = 0;
  logic req_ready, exc_valid, done, wr_valid;
  logic [4:0] exc_code;
  logic [AW-1:0] blk_addr, wr_addr;
  logic [8*BB-1:0] wr_data;
  logic [BB-1:0] wr_strb;

  int checks = 0, fails = 0, cycles = 0;

  always #10 clk = ~clk;

  cbo_guard #(.AW(AW), .BLK_BYTES(BLK), .BEAT_BYTES(BB)) dut (.*);

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected cause from the requirements; 0 = permitted
  function automatic int exp_code(int op, int pr, bit vt, logic [2:0] m, logic [2:0] h,
                                  logic [2:0] s, bit ld, bit st);
    int b = (op == 0) ? 0 : ((op == 3) ? 2 : 1);
    bit below_m = (pr != 3), at_or_below_s = (pr <= 1), user = (pr == 0);
    if (below_m && m[b] == 0) return 2;
    if (vt && ((at_or_below_s && h[b] == 0) || (user && s[b] == 0))) return 22;
    if (!vt && user && s[b] == 0) return 2;
    if (op == 0) return st ? 0 : 7;
    return (ld || st) ? 0 : 7;
  endfunction

  task automatic drive(int op, int pr, bit vt, logic [2:0] m, logic [2:0] h, logic [2:0] s,
                       logic [AW-1:0] a, bit ld, bit st);
    req_valid = 1; req_op = op[1:0]; req_priv = pr[1:0]; req_virt = vt;
    cfg_menv = m; cfg_henv = h; cfg_senv = s; req_addr = a;
    probe_ld_ok = ld; probe_st_ok = st;
  endtask

  // consume a burst whose first beat is visible now; returns at the negedge after the last take
  task automatic burst(logic [AW-1:0] base, bit rand_ready);
    int taken = 0;
    while (taken < BEATS) begin
      wr_ready = rand_ready ? ($urandom % 3 != 0) : 1'b1;
      #1;
      check(wr_valid == 1, "R9 beat valid", wr_valid, 1);
      check(wr_addr == base + AW'(taken * BB), "R9 beat address", wr_addr, base + AW'(taken * BB));
      check(wr_data == 0 && wr_strb == '1, "R9 beat payload", wr_strb, 8'hff);
      check(req_ready == (wr_ready && taken == BEATS - 1), "R12 ready in burst", req_ready,
            wr_ready && taken == BEATS - 1);
      @(negedge clk);
      if (wr_ready) taken++;
    end
    wr_ready = 0;
  endtask

  task automatic run_op(int op, int pr, bit vt, logic [2:0] m, logic [2:0] h, logic [2:0] s,
                        logic [AW-1:0] a, bit ld, bit st, bit rand_ready);
    int ec = exp_code(op, pr, vt, m, h, s, ld, st);
    logic [AW-1:0] ba = a & ~AW'(BLK - 1);
    @(negedge clk);
    drive(op, pr, vt, m, h, s, a, ld, st);
    @(negedge clk);
    req_valid = 0;
    check(exc_valid == (ec != 0), "R1 R2 R3 R4 R7 R8 exception flag", exc_valid, ec != 0);
    if (ec != 0) check(exc_code == ec[4:0], "R5 cause code", exc_code, ec);
    check(blk_addr == ba, "R6 aligned address", blk_addr, ba);
    if (ec != 0) check(wr_valid == 0 && done == 0, "R10 no write on exception", wr_valid, 0);
    else if (op != 0) check(done == 1 && wr_valid == 0, "R11 done after check", done, 1);
    else begin
      check(done == 0, "R11 no early done", done, 0);
      burst(ba, rand_ready);
      check(done == 1 && wr_valid == 0, "R11 done after last beat", done, 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check(req_ready == 1 && exc_valid == 0 && done == 0 && wr_valid == 0, "R13 reset state",
          {req_ready, exc_valid, done, wr_valid}, 4'b1000);

    // directed corner cases
    run_op(1, 1, 0, 3'b000, 3'b111, 3'b111, 32'h1234, 1, 1, 0); // R1 machine bit clear
    run_op(3, 3, 0, 3'b000, 3'b000, 3'b000, 32'h40, 0, 0, 0);   // machine ignores enables, both denied -> 7 (R8)
    run_op(2, 3, 0, 3'b000, 3'b000, 3'b000, 32'h80, 0, 1, 0);   // R8 store fallback succeeds
    run_op(0, 1, 1, 3'b111, 3'b110, 3'b111, 32'h77, 1, 1, 0);   // R2 hypervisor bit for zero
    run_op(3, 0, 1, 3'b111, 3'b111, 3'b011, 32'h9, 1, 1, 0);    // R2 supervisor bit under virt
    run_op(1, 0, 0, 3'b111, 3'b000, 3'b101, 32'h9, 1, 1, 0);    // R3 and R4 bit 1
    run_op(2, 0, 1, 3'b000, 3'b000, 3'b000, 32'h9, 0, 0, 0);    // R5 machine check wins
    run_op(0, 1, 0, 3'b001, 3'b000, 3'b000, 32'h5ff, 1, 0, 0);  // R7 zero lacks store
    run_op(0, 0, 0, 3'b001, 3'b000, 3'b001, 32'hdead_beef, 0, 1, 1); // R9 random ready burst

    // R12 back-to-back: refused request taken on the last beat
    @(negedge clk);
    drive(0, 3, 0, 3'b000, 3'b000, 3'b000, 32'h1000_0013, 0, 1);
    @(negedge clk);
    req_valid = 0;
    wr_ready = 1;
    for (int j = 1; j <= BEATS; j++) begin
      if (j == BEATS) drive(1, 0, 0, 3'b101, 3'b000, 3'b111, 32'h2000_0000, 1, 1);
      #1;
      if (j == BEATS) check(req_ready == 1, "R12 ready on last beat", req_ready, 1);
      @(negedge clk);
    end
    req_valid = 0; wr_ready = 0;
    check(done == 1 && exc_valid == 1, "R12 done with next exception", {done, exc_valid}, 2'b11);
    check(exc_code == 5'd2 && wr_valid == 0, "R12 next cause", exc_code, 2);

    // R12 back-to-back: new zero request restarts the burst
    @(negedge clk);
    drive(0, 3, 0, 3'b000, 3'b000, 3'b000, 32'h3000_0100, 0, 1);
    @(negedge clk);
    req_valid = 0;
    wr_ready = 1;
    for (int j = 1; j <= BEATS; j++) begin
      if (j == BEATS) drive(0, 3, 0, 3'b000, 3'b000, 3'b000, 32'h4000_0040, 0, 1);
      @(negedge clk);
    end
    req_valid = 0;
    check(done == 1 && wr_valid == 1, "R12 done with new burst", {done, wr_valid}, 2'b11);
    burst(32'h4000_0040, 0);
    check(done == 1, "R11 second burst done", done, 1);

    // constrained random
    void'($urandom(32'h5eed));
    for (int i = 0; i < 400; i++) begin
      int op = $urandom % 4;
      int sel = $urandom % 8;
      int pr = (sel < 3) ? 0 : (sel < 6) ? 1 : (sel < 7) ? 3 : 2;
      run_op(op, pr, $urandom % 2, 3'($urandom), 3'($urandom), 3'($urandom),
             $urandom, $urandom % 2, $urandom % 2, $urandom % 2);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule